// File: doc/BRIEF.md
# MDIO Management Master

This block is the controller side of a two-wire station-management link to Ethernet PHY devices. A host writes a command word holding a PHY address, a PHY register address, a direction flag and a go flag. If it wants a write, it also loads a 16-bit data word first. The block then produces a complete management frame on MDIO, clocked by an MDC it derives from the system clock. For a read, it captures the PHY's reply into the same data word.

The host sees a busy flag, the latched command fields and the data word. A command is accepted only while the block is idle. The line is released whenever no frame is being driven, so an external pull-up holds it high. The PHY owns the line during the turnaround and data of a read.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for an accepted go. On go it moves to `ST_SYNC`.
- `ST_SYNC`: waits for the next MDC falling edge, then moves to `ST_PREAMBLE`.
- `ST_PREAMBLE`, `ST_SOF`, `ST_OPCODE`, `ST_PHYAD`, `ST_REGAD`, `ST_TURN` and `ST_DATA`: each field state stays for its bit count and advances to the next field state on the MDC falling edge that ends its last bit.
- `ST_FINISH`: entered from `ST_DATA`, at the same edge that clears busy. It lasts one clock, loads read data, and returns to `ST_IDLE`.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy is 0, mdio_oe is 0, cmd_reg is 0 and data_reg is 0.
- R2: Whenever busy is 0, mdio_oe is 0 (line released).
- R3: MDC is a free-running clock with a period of CLK_DIV system clocks, high and low for CLK_DIV/2 clocks each.
- R4: A frame opens with 32 driven ones, followed by the start pattern 0 then 1.
- R5: The two opcode bits are 0,1 for a write and 1,0 for a read.
- R6: The PHY address follows the opcode, then the register address, each 5 bits sent MSB first.
- R7: In a write, the block drives the turnaround as 1 then 0, then drives data_reg bit 15 down to bit 0. The block drives all 64 bits.
- R8: In a read, mdio_oe is 0 for the two turnaround bits and the 16 data bits. MDIO is sampled on each MDC rising edge of the data field, MSB first.
- R9: mdio_o and mdio_oe change only at system-clock edges where MDC falls.
- R10: A frame spans exactly 64 MDC periods. Busy clears at the MDC falling edge that ends the last data bit, and the line is then released.
- R11: For a read, busy clears one clock before data_reg takes the captured value. data_reg is unchanged in the first clock with busy low.
- R12: While busy is 1, host writes to either register are discarded. This covers command writes with go set and data writes, and the running frame is unaffected.
- R13: A command write (host_wr_sel=0) while idle latches write flag = bit 1, register address = bits 6:2 and PHY address = bits 11:7. Busy is set on the next clock only if bit 0 (go) is 1. A data write (host_wr_sel=1) loads data_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 1 | 0 selects the command register, 1 selects the data register |
| host_wr_data | input | 16 | Host write value |
| busy | output | 1 | Frame in progress |
| cmd_reg | output | 11 | Latched {PHY address, register address, write flag} |
| data_reg | output | 16 | Data word: write source, read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO driver enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
The bench builds the block with CLK_DIV set to 4 and keeps the default 5-bit address and 16-bit data widths. The short divider keeps each 64-bit frame to a few hundred clocks, so several reads and writes fit in one run. These include all-ones and all-zero addresses and data words with set bits at both ends. A small model of the PHY drives the turnaround and reply bits between MDC rising edges. With this model the read capture, the release of the line and the one-clock gap between busy clearing and the data update can all be seen at the ports.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PREAMBLE,
        ST_SOF,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA,
        ST_FINISH
    } mdio_state_e;

    localparam int PRE_BITS = 32;
    localparam int SOF_BITS = 2;
    localparam int OP_BITS  = 2;
    localparam int TA_BITS  = 2;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_DRIVE = 2'b10;

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        if (cnt == CW'(CLK_DIV - 1)) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt + CW'(1);
        end
        tick_rise = (cnt == CW'(HALF - 1));
        tick_fall = (cnt == CW'(CLK_DIV - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            mdc <= (cnt_nxt >= CW'(HALF));
        end
    end

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs #(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              start,
    output logic              is_write,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] data_q
);
    localparam int GO_POS  = 0;
    localparam int DIR_POS = 1;
    localparam int REG_POS = 2;
    localparam int PHY_POS = REG_POS + REG_AW;

    logic accept_cmd;
    logic accept_dat;

    always_comb begin
        accept_cmd = wr_en && !busy && !wr_sel;
        accept_dat = wr_en && !busy && wr_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            start    <= 1'b0;
            is_write <= 1'b0;
            phy_addr <= '0;
            reg_addr <= '0;
        end else begin
            start <= accept_cmd && wr_data[GO_POS];
            if (accept_cmd) begin
                is_write <= wr_data[DIR_POS];
                reg_addr <= wr_data[REG_POS +: REG_AW];
                phy_addr <= wr_data[PHY_POS +: PHY_AW];
                if (wr_data[GO_POS]) begin
                    busy <= 1'b1;
                end
            end else if (done) begin
                busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept_dat) begin
            data_q <= wr_data;
        end else if (load) begin
            data_q <= load_data;
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick_rise,
    input  logic              tick_fall,
    input  logic              is_write,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              load,
    output logic [DATA_W-1:0] rdata
);
    localparam int FRAME_W = SOF_BITS + OP_BITS + PHY_AW + REG_AW + TA_BITS + DATA_W;
    localparam int MAXF    = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int CNT_W   = $clog2(MAXF + 1);

    mdio_state_e        state;
    mdio_state_e        state_nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [FRAME_W-1:0] sh;
    logic               wr_q;
    logic [DATA_W-1:0]  cap;
    logic               last_bit;
    logic               drive;

    function automatic int field_len(input mdio_state_e s);
        unique case (s)
            ST_PREAMBLE: return PRE_BITS;
            ST_SOF:      return SOF_BITS;
            ST_OPCODE:   return OP_BITS;
            ST_PHYAD:    return PHY_AW;
            ST_REGAD:    return REG_AW;
            ST_TURN:     return TA_BITS;
            ST_DATA:     return DATA_W;
            default:     return 1;
        endcase
    endfunction

    assign last_bit = (bit_cnt == CNT_W'(field_len(state) - 1));

    // next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = bit_cnt;
        done      = 1'b0;
        load      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nxt = ST_SYNC;
            end
            ST_SYNC: begin
                if (tick_fall) begin
                    state_nxt = ST_PREAMBLE;
                    cnt_nxt   = '0;
                end
            end
            ST_PREAMBLE: begin
                if (tick_fall) begin
                    if (last_bit) begin
                        state_nxt = ST_SOF;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = bit_cnt + CNT_W'(1);
                    end
                end
            end
            ST_SOF: begin
                if (tick_fall) begin
                    if (last_bit) begin
                        state_nxt = ST_OPCODE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = bit_cnt + CNT_W'(1);
                    end
                end
            end
            ST_OPCODE: begin
                if (tick_fall) begin
                    if (last_bit) begin
                        state_nxt = ST_PHYAD;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = bit_cnt + CNT_W'(1);
                    end
                end
            end
            ST_PHYAD: begin
                if (tick_fall) begin
                    if (last_bit) begin
                        state_nxt = ST_REGAD;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = bit_cnt + CNT_W'(1);
                    end
                end
            end
            ST_REGAD: begin
                if (tick_fall) begin
                    if (last_bit) begin
                        state_nxt = ST_TURN;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = bit_cnt + CNT_W'(1);
                    end
                end
            end
            ST_TURN: begin
                if (tick_fall) begin
                    if (last_bit) begin
                        state_nxt = ST_DATA;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = bit_cnt + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (tick_fall) begin
                    if (last_bit) begin
                        state_nxt = ST_FINISH;
                        cnt_nxt   = '0;
                        done      = 1'b1;
                    end else begin
                        cnt_nxt = bit_cnt + CNT_W'(1);
                    end
                end
            end
            ST_FINISH: begin
                state_nxt = ST_IDLE;
                load      = !wr_q;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            wr_q    <= 1'b0;
            cap     <= '0;
        end else begin
            state   <= state_nxt;
            bit_cnt <= cnt_nxt;
            if (state == ST_IDLE && start) begin
                wr_q <= is_write;
                sh   <= {SOF_CODE, (is_write ? OP_WRITE : OP_READ),
                         phy_addr, reg_addr, TA_DRIVE, wdata};
            end else if (tick_fall && state inside {ST_SOF, ST_OPCODE, ST_PHYAD,
                                                    ST_REGAD, ST_TURN, ST_DATA}) begin
                sh <= {sh[FRAME_W-2:0], 1'b0};
            end
            if (tick_rise && state == ST_DATA && !wr_q) begin
                cap <= {cap[DATA_W-2:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        drive = (state inside {ST_PREAMBLE, ST_SOF, ST_OPCODE, ST_PHYAD, ST_REGAD})
             || (wr_q && (state inside {ST_TURN, ST_DATA}));
        mdio_oe = drive;
        if (!drive || state == ST_PREAMBLE) begin
            mdio_o = 1'b1;
        end else begin
            mdio_o = sh[FRAME_W-1];
        end
        rdata = cap;
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int CLK_DIV = 8,
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr_en,
    input  logic                     host_wr_sel,
    input  logic [DATA_W-1:0]        host_wr_data,
    output logic                     busy,
    output logic [PHY_AW+REG_AW:0]   cmd_reg,
    output logic [DATA_W-1:0]        data_reg,
    output logic                     mdc,
    output logic                     mdio_o,
    output logic                     mdio_oe,
    input  logic                     mdio_i
);
    logic              tick_rise;
    logic              tick_fall;
    logic              start;
    logic              is_write;
    logic [PHY_AW-1:0] phy_addr;
    logic [REG_AW-1:0] reg_addr;
    logic              done;
    logic              load;
    logic [DATA_W-1:0] rdata;

    mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    mdio_host_regs #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr_en),
        .wr_sel    (host_wr_sel),
        .wr_data   (host_wr_data),
        .done      (done),
        .load      (load),
        .load_data (rdata),
        .busy      (busy),
        .start     (start),
        .is_write  (is_write),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .data_q    (data_reg)
    );

    mdio_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall),
        .is_write  (is_write),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wdata     (data_reg),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .load      (load),
        .rdata     (rdata)
    );

    assign cmd_reg = {phy_addr, reg_addr, is_write};

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int CLK_DIV = 8,
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_wr_en,
    input logic                   host_wr_sel,
    input logic                   go_bit,
    input logic                   busy,
    input logic [PHY_AW+REG_AW:0] cmd_reg,
    input logic [DATA_W-1:0]      data_reg,
    input logic                   mdc,
    input logic                   mdio_o,
    input logic                   mdio_oe
);
    localparam int HALF = CLK_DIV / 2;
    localparam int HW   = $clog2(CLK_DIV + 1);

    logic [HW-1:0] level_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_cnt <= '0;
        end else if (mdc != $past(mdc)) begin
            level_cnt <= HW'(1);
        end else begin
            level_cnt <= level_cnt + HW'(1);
        end
    end

    // R2
    line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R3
    mdc_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != $past(mdc)) |-> ($past(level_cnt) == HW'(HALF - 1)));

    // R9
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))) |-> $fell(mdc));

    // R11
    data_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $stable(data_reg));

    // R12
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_reg));

    // R12
    data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_reg));

    // R13
    go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !host_wr_sel && go_bit && !busy) |=> busy);

endmodule

bind mdio_master mdio_master_chk #(
    .CLK_DIV (CLK_DIV),
    .PHY_AW  (PHY_AW),
    .REG_AW  (REG_AW),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr_en  (host_wr_en),
    .host_wr_sel (host_wr_sel),
    .go_bit      (host_wr_data[0]),
    .busy        (busy),
    .cmd_reg     (cmd_reg),
    .data_reg    (data_reg),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int HALF       = DIV / 2;
    localparam int NVEC       = 4;

    // {poke, wr, phy[4:0], reg[4:0], wdata[15:0], phy_reply[15:0]}
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 5'h01, 5'h00, 16'hA5C3, 16'h0000},
        {1'b0, 1'b0, 5'h1F, 5'h1F, 16'h3C3C, 16'h8001},
        {1'b1, 1'b1, 5'h12, 5'h0D, 16'hFFFF, 16'h0000},
        {1'b0, 1'b0, 5'h00, 5'h10, 16'h0001, 16'h7E5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_wr_sel = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        busy;
    logic [10:0] cmd_reg;
    logic [15:0] data_reg;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        phy_line = 1'b1;
    logic        mdio_i;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    assign mdio_i = mdio_oe ? mdio_o : phy_line;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_master #(.CLK_DIV(DIV)) u_mdio_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_sel  (host_wr_sel),
        .host_wr_data (host_wr_data),
        .busy         (busy),
        .cmd_reg      (cmd_reg),
        .data_reg     (data_reg),
        .mdc          (mdc),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .mdio_i       (mdio_i)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        host_wr_en   = 1'b1;
        host_wr_sel  = sel;
        host_wr_data = d;
        @(posedge clk); #1;
        host_wr_en   = 1'b0;
    endtask

    task automatic run_entry(input logic [43:0] v, input bit time_period);
        logic        poke = v[43];
        logic        wr   = v[42];
        logic [4:0]  phy  = v[41:37];
        logic [4:0]  rg   = v[36:32];
        logic [15:0] wd   = v[31:16];
        logic [15:0] pd   = v[15:0];
        logic [63:0] line_bits = '0;
        logic [63:0] oe_bits = '0;
        logic [63:0] exp_line;
        logic [63:0] exp_oe;
        logic        prev_mdc;
        int          nrise = 0;
        int          guard = 0;
        int          poke_step = 0;
        int          t1 = 0;
        int          t2 = 0;
        int          n = 0;
        bit          started = 0;

        exp_line = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, (wr ? wd : pd)};
        exp_oe   = wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000;

        phy_line = 1'b1;
        host_write(1'b1, wd);
        host_write(1'b0, {4'b0, phy, rg, wr, 1'b1});
        check(busy == 1'b1, "R13", "busy after go", 64'(busy), 64'd1);
        prev_mdc = mdc;
        while (nrise < 64 && guard < 5000) begin
            @(posedge clk); #1;
            guard++;
            if (poke_step == 1) begin
                host_wr_en = 1'b1; host_wr_sel = 1'b1; host_wr_data = 16'h1234;
                poke_step = 2;
            end else if (poke_step == 2) begin
                host_wr_en = 1'b0;
                poke_step = 3;
            end
            if (mdc && !prev_mdc) begin
                if (!started && mdio_oe) started = 1;
                if (started) begin
                    line_bits[63 - nrise] = mdio_oe ? mdio_o : phy_line;
                    oe_bits[63 - nrise]   = mdio_oe;
                    nrise++;
                    if (nrise == 1) t1 = cyc;
                    if (nrise == 2) t2 = cyc;
                    if (!wr && nrise == 47) phy_line = 1'b0;
                    else if (!wr && nrise >= 48 && nrise < 64) phy_line = pd[63 - nrise];
                    else phy_line = 1'b1;
                    if (poke && nrise == 10) begin
                        host_wr_en = 1'b1; host_wr_sel = 1'b0;
                        host_wr_data = {4'b0, 5'h07, 5'h03, 1'b0, 1'b1};
                        poke_step = 1;
                    end
                end
            end
            prev_mdc = mdc;
        end
        phy_line = 1'b1;
        if (time_period) check(t2 - t1 == DIV, "R3", "mdc period", 64'(t2 - t1), 64'(DIV));
        check(line_bits[63:30] == exp_line[63:30], "R4", "preamble+sof", line_bits, exp_line);
        check(line_bits[29:28] == exp_line[29:28], "R5", "opcode", 64'(line_bits[29:28]), 64'(exp_line[29:28]));
        check(line_bits[27:18] == exp_line[27:18], "R6", "addresses", 64'(line_bits[27:18]), 64'(exp_line[27:18]));
        if (wr) begin
            check(line_bits[17:0] == exp_line[17:0], "R7", "write ta+data", 64'(line_bits[17:0]), 64'(exp_line[17:0]));
            check(oe_bits == exp_oe, "R7", "write drive", oe_bits, exp_oe);
        end else begin
            check(oe_bits == exp_oe, "R8", "read release", oe_bits, exp_oe);
        end
        while (busy && n < 1000) begin
            @(posedge clk); #1;
            n++;
        end
        check(n == HALF, "R10", "clocks last rise to busy low", 64'(n), 64'(HALF));
        check(mdio_oe == 1'b0, "R10", "line released at end", 64'(mdio_oe), 64'd0);
        check(data_reg == wd, "R11", "data held when busy drops", 64'(data_reg), 64'(wd));
        @(posedge clk); #1;
        if (wr) begin
            check(data_reg == wd, "R12", "data after write frame", 64'(data_reg), 64'(wd));
        end else begin
            check(data_reg == pd, "R8", "captured read data", 64'(data_reg), 64'(pd));
        end
        if (poke) begin
            check(cmd_reg == {phy, rg, wr}, "R12", "cmd ignored while busy", 64'(cmd_reg), 64'({phy, rg, wr}));
            check(busy == 1'b0, "R12", "ignored go started nothing", 64'(busy), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
        check(mdio_oe == 1'b0, "R1", "oe", 64'(mdio_oe), 64'd0);
        check(cmd_reg == '0, "R1", "cmd", 64'(cmd_reg), 64'd0);
        check(data_reg == '0, "R1", "data", 64'(data_reg), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        for (int i = 0; i < NVEC; i++) begin
            run_entry(VEC[i], i == 0);
            repeat (3) @(posedge clk);
            #1;
        end

        // R13: command without go only loads fields
        host_write(1'b0, {4'b0, 5'h03, 5'h04, 1'b1, 1'b0});
        check(cmd_reg == {5'h03, 5'h04, 1'b1}, "R13", "fields latched", 64'(cmd_reg), 64'({5'h03, 5'h04, 1'b1}));
        begin
            bit oe_seen = 0;
            bit busy_seen = 0;
            for (int k = 0; k < 4 * DIV; k++) begin
                @(posedge clk); #1;
                if (mdio_oe) oe_seen = 1;
                if (busy) busy_seen = 1;
            end
            check(!busy_seen, "R13", "no go no busy", 64'(busy_seen), 64'd0);
            check(!oe_seen, "R2", "idle line released", 64'(oe_seen), 64'd0);
        end

        // R13: data write while idle
        host_write(1'b1, 16'hBEEF);
        check(data_reg == 16'hBEEF, "R13", "data write idle", 64'(data_reg), 64'hBEEF);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule